// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a two-level page table that sits in word-addressed memory and makes two dependent reads. A requester hands over a logical address through a valid/ready handshake. The walker compares the top field against a programmed table length. If the field is in range, it reads the outer-table entry at the programmed base plus that field. It then reads the inner-table entry selected by the middle field. The result comes back as a one-cycle response carrying either the physical address or a fault with its cause.

The block has no translation cache. Every successful translation therefore costs exactly two table reads, and an out-of-range outer index costs none. A small configuration port loads the outer-table base and the outer-table length. The memory port issues one-cycle read strobes and accepts the read data whenever it arrives, so any latency of one cycle or more is supported.

Top module: `pt_walker`

## Requirements
- R1: On a successful translation, `rsp_paddr[9:0]` equals bits [9:0] of the accepted logical address.
- R2: The logical address splits as outer index = bits [31:20], inner index = bits [19:10] and offset = bits [9:0]. The first read of a walk goes to word address base + outer index.
- R3: An entry's bit 0 is its valid flag and bits [31:10] are its 22-bit pointer. The second read goes to word address {outer pointer, inner index}.
- R4: A successful response has `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = {inner pointer, offset}. Entry bits [9:1] have no effect.
- R5: When the outer index is greater than or equal to the length register, the walker issues no memory read. It responds on the cycle after acceptance with `rsp_fault`=1, `rsp_cause`=1 and `rsp_paddr`=0.
- R6: An outer entry with bit 0 clear ends the walk after one read, with `rsp_fault`=1, `rsp_cause`=2 and `rsp_paddr`=0.
- R7: An inner entry with bit 0 clear ends the walk after two reads, with `rsp_fault`=1, `rsp_cause`=3 and `rsp_paddr`=0.
- R8: A successful translation issues exactly two reads, each a one-cycle `mem_req` strobe. This holds for any read latency.
- R9: `req_ready` is high only while no walk is in progress. A `req_valid` raised during a walk neither changes the walk nor starts another one.
- R10: Synchronous active-high reset gives `req_ready`=1, `rsp_valid`=0 and `mem_req`=0, and clears base and length to 0, so any request after reset takes the R5 fault.
- R11: `rsp_valid` is high for exactly one cycle per response. A `mem_rvalid` that arrives while no read is outstanding is ignored.
- R12: A configuration write with `cfg_sel`=0 loads the base from `cfg_wdata`. A write with `cfg_sel`=1 loads the length from `cfg_wdata[12:0]`, so values 0 to 4096 are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 ok, 1 out of bounds, 2 outer invalid, 3 inner invalid |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 32 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (a table entry) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects base, 1 selects length |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
The bench builds the walker with its default field widths of 12, 10 and 10 bits and 32-bit entries. With these widths the largest outer index, 4095, and the largest length, 4096, can be programmed, so both edges of the bound comparison are exercised. The bench memory's latency is varied between one and four cycles. The longer latency leaves room to present a competing request while a walk is in progress and to inject a stray read return while the walker is idle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int DEF_OUT_W = 12;
    localparam int DEF_IN_W  = 10;
    localparam int DEF_OFF_W = 10;
    localparam int DEF_ENT_W = 32;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_OUTER = 2'd1,
        WS_INNER = 2'd2
    } walk_state_e;

    typedef enum logic [1:0] {
        WF_NONE  = 2'd0,
        WF_BOUND = 2'd1,
        WF_OUTER = 2'd2,
        WF_INNER = 2'd3
    } walk_fault_e;

    typedef struct packed {
        logic        fault;
        walk_fault_e cause;
    } walk_result_s;

    function automatic walk_result_s mk_fault(walk_fault_e c);
        walk_result_s r;
        r.fault = (c != WF_NONE);
        r.cause = c;
        return r;
    endfunction

endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs #(
    parameter int MA_W  = 32,
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [MA_W-1:0]  cfg_wdata,
    output logic [MA_W-1:0]  base_q,
    output logic [LEN_W-1:0] len_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            len_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) len_q  <= cfg_wdata[LEN_W-1:0];
            else         base_q <= cfg_wdata;
        end
    end

    a_r12_len_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel) |=> (len_q == $past(cfg_wdata[LEN_W-1:0])));

    a_r12_base_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_sel) |=> (base_q == $past(cfg_wdata)));
endmodule

// File: rtl/pt_addr_split.sv
module pt_addr_split #(
    parameter int OUT_W = 12,
    parameter int IN_W  = 10,
    parameter int OFF_W = 10,
    localparam int VA_W = OUT_W + IN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [VA_W-1:0]  vaddr,
    output logic [OUT_W-1:0] outer_now,
    output logic [IN_W-1:0]  inner_q,
    output logic [OFF_W-1:0] off_q
);
    assign outer_now = vaddr[VA_W-1 -: OUT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            inner_q <= '0;
            off_q   <= '0;
        end else if (load) begin
            inner_q <= vaddr[OFF_W +: IN_W];
            off_q   <= vaddr[OFF_W-1:0];
        end
    end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int OUT_W = 12,
    parameter int IN_W  = 10,
    parameter int OFF_W = 10,
    parameter int ENT_W = 32,
    localparam int PTR_W = ENT_W - OFF_W,
    localparam int MA_W  = PTR_W + IN_W,
    localparam int LEN_W = OUT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [OUT_W-1:0] outer_now,
    input  logic [IN_W-1:0]  inner_q,
    input  logic [OFF_W-1:0] off_q,
    input  logic [MA_W-1:0]  base_q,
    input  logic [LEN_W-1:0] len_q,
    output logic             mem_req,
    output logic [MA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             rsp_valid,
    output walk_result_s     rsp_res,
    output logic [ENT_W-1:0] rsp_paddr
);
    walk_state_e      state;
    logic             ent_ok;
    logic [PTR_W-1:0] ent_ptr;
    logic             in_bound;
    logic             unused_rsvd;

    assign ent_ok      = mem_rdata[0];
    assign ent_ptr     = mem_rdata[ENT_W-1:OFF_W];
    assign unused_rsvd = ^mem_rdata[OFF_W-1:1];
    assign in_bound    = ({1'b0, outer_now} < len_q);
    assign req_ready   = (state == WS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WS_IDLE;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_res   <= mk_fault(WF_NONE);
            rsp_paddr <= '0;
        end else begin
            mem_req   <= 1'b0;
            rsp_valid <= 1'b0;
            unique case (state)
                WS_IDLE: if (req_valid) begin
                    if (in_bound) begin
                        mem_req  <= 1'b1;
                        mem_addr <= base_q + MA_W'(outer_now);
                        state    <= WS_OUTER;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_res   <= mk_fault(WF_BOUND);
                        rsp_paddr <= '0;
                    end
                end
                WS_OUTER: if (mem_rvalid) begin
                    if (ent_ok) begin
                        mem_req  <= 1'b1;
                        mem_addr <= {ent_ptr, inner_q};
                        state    <= WS_INNER;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_res   <= mk_fault(WF_OUTER);
                        rsp_paddr <= '0;
                        state     <= WS_IDLE;
                    end
                end
                WS_INNER: if (mem_rvalid) begin
                    rsp_valid <= 1'b1;
                    state     <= WS_IDLE;
                    if (ent_ok) begin
                        rsp_res   <= mk_fault(WF_NONE);
                        rsp_paddr <= {ent_ptr, off_q};
                    end else begin
                        rsp_res   <= mk_fault(WF_INNER);
                        rsp_paddr <= '0;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // R9: a read strobe only exists while a walk is in progress
    a_r9_busy_when_reading: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R5: a bound fault response is never accompanied by a read
    a_r5_bound_no_read: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_res.cause == WF_BOUND) |-> !mem_req);

    // R1: a good response keeps the latched offset
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_res.fault) |-> (rsp_paddr[OFF_W-1:0] == off_q));

    // R3: the second read lands on the latched inner index
    a_r3_inner_index: assert property (@(posedge clk) disable iff (rst)
        (mem_req && state == WS_INNER) |-> (mem_addr[IN_W-1:0] == inner_q));

    // R6/R7: every fault response carries a zero address
    a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_res.fault) |-> (rsp_paddr == '0));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int OUT_W = DEF_OUT_W,
    parameter int IN_W  = DEF_IN_W,
    parameter int OFF_W = DEF_OFF_W,
    parameter int ENT_W = DEF_ENT_W,
    localparam int VA_W  = OUT_W + IN_W + OFF_W,
    localparam int PTR_W = ENT_W - OFF_W,
    localparam int MA_W  = PTR_W + IN_W,
    localparam int LEN_W = OUT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause,
    output logic [ENT_W-1:0] rsp_paddr,
    output logic             mem_req,
    output logic [MA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [MA_W-1:0]  cfg_wdata
);
    logic [MA_W-1:0]  base_q;
    logic [LEN_W-1:0] len_q;
    logic [OUT_W-1:0] outer_now;
    logic [IN_W-1:0]  inner_q;
    logic [OFF_W-1:0] off_q;
    walk_result_s     rsp_res;

    pt_cfg_regs #(.MA_W(MA_W), .LEN_W(LEN_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .len_q(len_q)
    );

    pt_addr_split #(.OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W)) u_split (
        .clk(clk), .rst(rst), .load(req_valid && req_ready),
        .vaddr(req_vaddr), .outer_now(outer_now),
        .inner_q(inner_q), .off_q(off_q)
    );

    pt_walk_fsm #(.OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W), .ENT_W(ENT_W)) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .outer_now(outer_now), .inner_q(inner_q), .off_q(off_q),
        .base_q(base_q), .len_q(len_q),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_res(rsp_res), .rsp_paddr(rsp_paddr)
    );

    assign rsp_fault = rsp_res.fault;
    assign rsp_cause = rsp_res.cause;
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;

    pt_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
    );

    // memory model: word array, missing words read as 0 (invalid entry)
    logic [31:0] mem [logic [31:0]];
    int          lat = 1;
    int          cnt = 0;
    int          nreads = 0;
    logic [31:0] pend = '0;
    logic [31:0] rd_log [8];
    logic        mdl_rv = 1'b0;
    logic [31:0] mdl_rd = '0;
    logic        inj_rv = 1'b0;
    assign mem_rvalid = mdl_rv | inj_rv;
    assign mem_rdata  = inj_rv ? 32'hFFFF_FFFF : mdl_rd;

    always @(posedge clk) begin
        mdl_rv <= 1'b0;
        if (rst) begin
            cnt <= 0;
        end else if (mem_req) begin
            pend   <= mem_addr;
            cnt    <= lat;
            rd_log[nreads % 8] <= mem_addr;
            nreads <= nreads + 1;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                mdl_rv <= 1'b1;
                mdl_rd <= mem.exists(pend) ? mem[pend] : 32'h0;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] ent(input logic [21:0] ptr, input logic v);
        return {ptr, 9'h1A5, v};   // reserved bits deliberately nonzero (R4)
    endfunction

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    logic        w_fault;
    logic [1:0]  w_cause;
    logic [31:0] w_paddr;
    int          w_reads, w_cycles;
    logic [31:0] w_a0, w_a1;

    task automatic walk(input logic [31:0] va);
        int start;
        @(negedge clk);
        start = nreads;
        check("R9 ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        w_cycles = 1;
        while (!rsp_valid && w_cycles < 100) begin
            @(negedge clk);
            w_cycles++;
        end
        w_fault = rsp_fault; w_cause = rsp_cause; w_paddr = rsp_paddr;
        w_reads = nreads - start;
        w_a0 = rd_log[start % 8];
        w_a1 = rd_log[(start + 1) % 8];
        @(negedge clk);
        check("R11 response is one pulse", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 ready after reset", {31'b0, req_ready}, 32'd1);
        check("R10 no response after reset", {31'b0, rsp_valid}, 32'd0);
        check("R10 no read after reset", {31'b0, mem_req}, 32'd0);
        walk(32'h0000_0000);
        check("R10 length cleared gives bound fault", {30'b0, w_cause}, 32'd1);
        check("R10 no reads with length 0", w_reads, 0);
    endtask

    task automatic t_success(input int l);
        lat = l;
        walk({12'h000, 10'h003, 10'h155});
        check("R4 success fault flag", {31'b0, w_fault}, 32'd0);
        check("R4 success cause", {30'b0, w_cause}, 32'd0);
        check("R4 physical address", w_paddr, {22'h2AB0C, 10'h155});
        check("R1 offset kept", {22'b0, w_paddr[9:0]}, 32'h155);
        check("R8 two reads", w_reads, 2);
        check("R2 outer read address", w_a0, 32'h1000);
        check("R3 inner read address", w_a1, {22'h00005, 10'h003});
    endtask

    task automatic t_offset_edge;
        lat = 2;
        walk({12'h001, 10'h000, 10'h3FF});
        check("R1 max offset", w_paddr, {22'h12345, 10'h3FF});
        check("R2 outer read address idx1", w_a0, 32'h1001);
    endtask

    task automatic t_outer_invalid;
        lat = 3;
        walk({12'h002, 10'h011, 10'h022});
        check("R6 cause outer invalid", {30'b0, w_cause}, 32'd2);
        check("R6 fault flag", {31'b0, w_fault}, 32'd1);
        check("R6 fault address zero", w_paddr, 32'h0);
        check("R6 one read", w_reads, 1);
    endtask

    task automatic t_inner_invalid;
        lat = 1;
        walk({12'h001, 10'h3FF, 10'h001});
        check("R7 cause inner invalid", {30'b0, w_cause}, 32'd3);
        check("R7 fault address zero", w_paddr, 32'h0);
        check("R7 two reads", w_reads, 2);
        check("R3 inner read address max", w_a1, {22'h3FFFFF, 10'h3FF});
    endtask

    task automatic t_bound;
        walk({12'h008, 10'h000, 10'h000});
        check("R5 cause bound at length", {30'b0, w_cause}, 32'd1);
        check("R5 no read", w_reads, 0);
        check("R5 response cycle after accept", w_cycles, 1);
        check("R5 fault address zero", w_paddr, 32'h0);
        walk({12'h007, 10'h000, 10'h00A});
        check("R5 index below length walks", w_paddr, {22'h00001, 10'h00A});
        check("R5 below length two reads", w_reads, 2);
    endtask

    task automatic t_full_length;
        cfg_write(1'b1, 32'hFFFF_1000);   // R12: only bits [12:0] used -> 4096
        walk({12'hFFF, 10'h001, 10'h0C3});
        check("R12 length 4096 admits top index", {31'b0, w_fault}, 32'd0);
        check("R2 top outer address", w_a0, 32'h1FFF);
        check("R4 top index address", w_paddr, {22'h155AA, 10'h0C3});
        cfg_write(1'b1, 32'd8);
    endtask

    task automatic t_busy_ignored;
        int start;
        lat = 4;
        @(negedge clk);
        start = nreads;
        req_valid = 1'b1; req_vaddr = {12'h000, 10'h003, 10'h001};
        @(negedge clk);
        req_vaddr = {12'h009, 10'h000, 10'h000};   // out of bounds if taken
        check("R9 not ready while busy", {31'b0, req_ready}, 32'd0);
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        check("R9 first walk unaffected", rsp_paddr, {22'h2AB0C, 10'h001});
        check("R9 cause unaffected", {30'b0, rsp_cause}, 32'd0);
        check("R9 two reads only", nreads - start, 2);
        repeat (2) @(negedge clk);
        check("R9 no second response", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_stray;
        int start;
        @(negedge clk);
        start = nreads;
        inj_rv = 1'b1;
        @(negedge clk);
        inj_rv = 1'b0;
        check("R11 stray return no response", {31'b0, rsp_valid}, 32'd0);
        check("R11 stray return no read", {31'b0, mem_req}, 32'd0);
        check("R11 still ready", {31'b0, req_ready}, 32'd1);
        check("R11 no read count", nreads - start, 0);
        lat = 1;
        walk({12'h000, 10'h003, 10'h0AA});
        check("R11 next walk correct", w_paddr, {22'h2AB0C, 10'h0AA});
    endtask

    initial begin
        mem[32'h1000] = ent(22'h00005, 1'b1);
        mem[32'h1403] = ent(22'h2AB0C, 1'b1);
        mem[32'h1001] = ent(22'h3FFFFF, 1'b1);
        mem[{22'h3FFFFF, 10'h000}] = ent(22'h12345, 1'b1);
        mem[{22'h3FFFFF, 10'h3FF}] = ent(22'h0ABC0, 1'b0);
        mem[32'h1007] = ent(22'h00007, 1'b1);
        mem[{22'h00007, 10'h000}] = ent(22'h00001, 1'b1);
        mem[32'h1008] = ent(22'h00009, 1'b1);
        mem[32'h1FFF] = ent(22'h00008, 1'b1);
        mem[{22'h00008, 10'h001}] = ent(22'h155AA, 1'b1);

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        cfg_write(1'b0, 32'h0000_1000);
        cfg_write(1'b1, 32'd8);
        t_success(1);
        t_success(4);
        t_offset_edge();
        t_outer_invalid();
        t_inner_invalid();
        t_bound();
        t_full_length();
        t_busy_ignored();
        t_stray();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule